// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps the current time and date in packed BCD registers: seconds, minutes, hours, day of week, date, month and a two-digit year. A single-cycle enable, `src_tick`, stands for one period of the input clock source. A prescaler divides those enables down to one pulse per second. A control register picks which of six source rates the prescaler expects, and whether hours are kept in 24-hour form or in 12-hour form with a PM flag.

Software reaches every field through a plain register port. A write takes effect on the next clock edge. The read data is combinational from the read address. Counting keeps running while software reads. Every field that changes at a rollover changes on the same clock edge, so any read sees a consistent time. February gets 29 days when the two-digit year is a multiple of four.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, the registers read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01, year 0x00 and control 0x00.
- R2: Seconds (address 0) and minutes (address 1) hold BCD 00..59. Each one-second tick adds one to seconds. On 59 the field goes to 00 and the next field advances.
- R3: With control bit 0 clear (24-hour mode), hours (address 2) count BCD 00..23. The step from 23 to 00 advances the date.
- R4: With control bit 0 set (12-hour mode), hours bits 4:0 count BCD 12, 01, 02 .. 11 and bit 5 is the PM flag. The step from 11 to 12 toggles the flag, and the date advances only on the step from 11 PM to 12 AM.
- R5: Day of week (address 3) counts 1..7, wraps from 7 to 1, and advances on the same edge as the date.
- R6: Date (address 4) wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Month (address 5) wraps from 12 to 01 and advances the year (address 6), which wraps from 99 to 00.
- R7: February ends at 29 when the BCD year is divisible by 4 (including 00), and at 28 otherwise.
- R8: Control bits 3:1 select the source: 0, 1, 2, 3, 4 and 5 divide `src_tick` pulses by DIV_32K, DIV_1M, DIV_2M, DIV_4M, DIV_50 and DIV_60. Exactly that many pulses after the prescaler was cleared give one second. Codes 6 and 7 stop counting.
- R9: A write to addresses 0..7 stores `wr_data` in that field (control keeps bits 3:0), and `rd_data` returns the addressed field.
- R10: Any register write clears the prescaler, so the next second comes a full period of pulses later. A write in the same cycle as a due tick wins: the written value is stored and that tick is dropped.
- R11: At the rollover from 23:59:59 on 31 December 99 (day 7), all seven fields change on one clock edge, to 00:00:00 on 01 January 00 (day 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | One pulse per period of the selected input source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 seconds .. 6 year, 7 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for rd_addr, combinational |

## Verification
Two functions can meet in one cycle: a host write, and the prescaler's terminal count producing a one-second tick. The bench provokes this by counting source pulses up to one short of a full second. It then raises the write strobe together with the final pulse. It judges the outcome by checking that the written seconds value is stored unchanged, and that the next increment needs a full new period of pulses. A second pairing is a carry rippling through all seven fields at once. This is judged by reading every field after the single edge that ends the year.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [2:0] ADDR_SEC   = 3'd0;
  localparam logic [2:0] ADDR_MIN   = 3'd1;
  localparam logic [2:0] ADDR_HOUR  = 3'd2;
  localparam logic [2:0] ADDR_DOW   = 3'd3;
  localparam logic [2:0] ADDR_DATE  = 3'd4;
  localparam logic [2:0] ADDR_MONTH = 3'd5;
  localparam logic [2:0] ADDR_YEAR  = 3'd6;
  localparam logic [2:0] ADDR_CTRL  = 3'd7;

  localparam int unsigned NFIELD = 7;

  typedef enum logic [2:0] {
    SRC_32K    = 3'd0,
    SRC_1M     = 3'd1,
    SRC_2M     = 3'd2,
    SRC_4M     = 3'd3,
    SRC_LINE50 = 3'd4,
    SRC_LINE60 = 3'd5,
    SRC_OFF6   = 3'd6,
    SRC_OFF7   = 3'd7
  } src_sel_e;

  // add one to a packed two-digit BCD value (no wrap handling)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  // 10*T + O is a multiple of 4 exactly when 2*T[0] + O[1:0] is 0 mod 4
  function automatic logic leap_bcd(input logic [7:0] y);
    logic [1:0] s;
    s = {y[4], 1'b0} + y[1:0];
    return (s == 2'b00);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic leap);
    if (m == 8'h02) return leap ? 8'h29 : 8'h28;
    if (m == 8'h04 || m == 8'h06 || m == 8'h09 || m == 8'h11) return 8'h30;
    return 8'h31;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_32K = 32768,
  parameter int unsigned DIV_1M  = 1000000,
  parameter int unsigned DIV_2M  = 2000000,
  parameter int unsigned DIV_4M  = 4000000,
  parameter int unsigned DIV_50  = 50,
  parameter int unsigned DIV_60  = 60
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     src_tick,
  input  logic     clear,
  input  src_sel_e sel,
  output logic     tick
);

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned DMAX =
    max2(max2(max2(DIV_32K, DIV_1M), max2(DIV_2M, DIV_4M)), max2(DIV_50, DIV_60));
  localparam int CW = $clog2(DMAX) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          halt;

  always_comb begin
    halt  = 1'b0;
    limit = '0;
    case (sel)
      SRC_32K:    limit = CW'(DIV_32K - 1);
      SRC_1M:     limit = CW'(DIV_1M - 1);
      SRC_2M:     limit = CW'(DIV_2M - 1);
      SRC_4M:     limit = CW'(DIV_4M - 1);
      SRC_LINE50: limit = CW'(DIV_50 - 1);
      SRC_LINE60: limit = CW'(DIV_60 - 1);
      default:    halt  = 1'b1;
    endcase
  end

  // a clear in the same cycle swallows the pulse and the tick
  assign tick = src_tick && !halt && !clear && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear)             cnt <= '0;
    else if (src_tick && !halt) cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       mode12,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic       day_step
);

  localparam int NMOD60 = 2;

  logic [7:0]      mm_q [NMOD60];
  logic [NMOD60:0] carry;

  assign carry[0] = step;

  for (genvar i = 0; i < NMOD60; i++) begin : g_mod60
    logic wrap;
    assign wrap       = (mm_q[i] == 8'h59);
    assign carry[i+1] = carry[i] && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mm_q[i] <= 8'h00;
      else if (wr_sel[i]) mm_q[i] <= wr_data;
      else if (carry[i])  mm_q[i] <= wrap ? 8'h00 : bcd_inc(mm_q[i]);
    end
  end

  assign sec = mm_q[0];
  assign min = mm_q[1];

  logic [7:0] hour_q;
  logic [7:0] hour_nx;
  logic       day_wrap;
  logic [4:0] h12;
  logic       pm;

  assign h12 = hour_q[4:0];
  assign pm  = hour_q[5];

  always_comb begin
    if (mode12) begin
      day_wrap = (h12 == 5'h11) && pm;
      if (h12 == 5'h12)      hour_nx = {2'b00, pm, 5'h01};
      else if (h12 == 5'h11) hour_nx = {2'b00, ~pm, 5'h12};
      else if (h12[3:0] == 4'd9) hour_nx = {2'b00, pm, 5'h10};
      else                   hour_nx = {2'b00, pm, h12 + 5'd1};
    end else begin
      day_wrap = (hour_q == 8'h23);
      hour_nx  = day_wrap ? 8'h00 : bcd_inc(hour_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hour_q <= 8'h00;
    else if (wr_sel[2])     hour_q <= wr_data;
    else if (carry[NMOD60]) hour_q <= hour_nx;
  end

  assign hour     = hour_q;
  assign day_step = carry[NMOD60] && day_wrap;

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [3:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] dow,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year
);

  logic [7:0] dow_q, date_q, month_q, year_q;
  logic       date_wrap, month_wrap;
  logic       month_step, year_step;

  assign date_wrap  = (date_q == month_len(month_q, leap_bcd(year_q)));
  assign month_wrap = (month_q == 8'h12);
  assign month_step = step && date_wrap;
  assign year_step  = month_step && month_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dow_q <= 8'h01;
    else if (wr_sel[0]) dow_q <= wr_data;
    else if (step)      dow_q <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         date_q <= 8'h01;
    else if (wr_sel[1]) date_q <= wr_data;
    else if (step)      date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          month_q <= 8'h01;
    else if (wr_sel[2])  month_q <= wr_data;
    else if (month_step) month_q <= month_wrap ? 8'h01 : bcd_inc(month_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         year_q <= 8'h00;
    else if (wr_sel[3]) year_q <= wr_data;
    else if (year_step) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
  end

  assign dow   = dow_q;
  assign date  = date_q;
  assign month = month_q;
  assign year  = year_q;

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_32K = 32768,
  parameter int unsigned DIV_1M  = 1000000,
  parameter int unsigned DIV_2M  = 2000000,
  parameter int unsigned DIV_4M  = 4000000,
  parameter int unsigned DIV_50  = 50,
  parameter int unsigned DIV_60  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);

  logic [NFIELD-1:0] field_wr;
  logic [3:0]        ctrl_q;
  logic              mode12;
  logic              sec_tick;
  logic              day_step;
  logic [7:0]        sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q;

  for (genvar i = 0; i < NFIELD; i++) begin : g_dec
    assign field_wr[i] = wr_en && (wr_addr == 3'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctrl_q <= 4'h0;
    else if (wr_en && wr_addr == ADDR_CTRL)  ctrl_q <= wr_data[3:0];
  end

  assign mode12 = ctrl_q[0];

  rtc_prescaler #(
    .DIV_32K(DIV_32K), .DIV_1M(DIV_1M), .DIV_2M(DIV_2M),
    .DIV_4M(DIV_4M), .DIV_50(DIV_50), .DIV_60(DIV_60)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .clear    (wr_en),
    .sel      (src_sel_e'(ctrl_q[3:1])),
    .tick     (sec_tick)
  );

  rtc_time_chain u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (sec_tick),
    .mode12   (mode12),
    .wr_sel   (field_wr[2:0]),
    .wr_data  (wr_data),
    .sec      (sec_q),
    .min      (min_q),
    .hour     (hour_q),
    .day_step (day_step)
  );

  rtc_date_chain u_date (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (day_step),
    .wr_sel  (field_wr[6:3]),
    .wr_data (wr_data),
    .dow     (dow_q),
    .date    (date_q),
    .month   (month_q),
    .year    (year_q)
  );

  always_comb begin
    case (rd_addr)
      ADDR_SEC:   rd_data = sec_q;
      ADDR_MIN:   rd_data = min_q;
      ADDR_HOUR:  rd_data = hour_q;
      ADDR_DOW:   rd_data = dow_q;
      ADDR_DATE:  rd_data = date_q;
      ADDR_MONTH: rd_data = month_q;
      ADDR_YEAR:  rd_data = year_q;
      default:    rd_data = {4'h0, ctrl_q};
    endcase
  end

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       src_tick,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       sec_tick,
  input logic       mode12,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] date,
  input logic [7:0] month
);

  a_r8_tick_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> src_tick);

  a_r10_write_blocks_tick: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !sec_tick);

  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (sec == $past(wr_data)));

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec == 8'h59) |=> (sec == 8'h00));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hour)
                               && $stable(date) && $stable(month)));

  a_r4_pm_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && mode12 && sec == 8'h59 && min == 8'h59 && hour[4:0] == 5'h11)
      |=> (hour[5] != $past(hour[5])));

  a_r6_month_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !mode12 && sec == 8'h59 && min == 8'h59 && hour == 8'h23
     && date == 8'h31 && month == 8'h12) |=> (month == 8'h01 && date == 8'h01));

endmodule

bind bcd_rtc rtc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_tick (src_tick),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .sec_tick (sec_tick),
  .mode12   (mode12),
  .sec      (sec_q),
  .min      (min_q),
  .hour     (hour_q),
  .date     (date_q),
  .month    (month_q)
);

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;

  localparam int CLK_PERIOD = 10;
  localparam int D0 = 3, D1 = 4, D2 = 5, D3 = 9, D4 = 2, D5 = 6;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc #(.DIV_32K(D0), .DIV_1M(D1), .DIV_2M(D2), .DIV_4M(D3),
            .DIV_50(D4), .DIV_60(D5)) u0 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] enc12(input int h);
    int hh;
    logic [7:0] b;
    hh = h % 12;
    if (hh == 0) hh = 12;
    b = bcd(hh);
    return {2'b00, (h >= 12), b[4:0]};
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rchk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, $sformatf("addr%0d", a), d, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      src_tick = 1'b1;
      @(negedge clk);
    end
    src_tick = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                         input logic [7:0] dw, input logic [7:0] dt,
                         input logic [7:0] mo, input logic [7:0] y);
    wr(3'd0, s); wr(3'd1, mi); wr(3'd2, h); wr(3'd3, dw);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, y);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rchk("R1", 3'd0, 8'h00); rchk("R1", 3'd1, 8'h00); rchk("R1", 3'd2, 8'h00);
    rchk("R1", 3'd3, 8'h01); rchk("R1", 3'd4, 8'h01); rchk("R1", 3'd5, 8'h01);
    rchk("R1", 3'd6, 8'h00); rchk("R1", 3'd7, 8'h00);

    // R9 write and read back each field
    for (int a = 0; a < 7; a++) begin
      wr(3'(a), bcd(a + 11));
      rchk("R9", 3'(a), bcd(a + 11));
    end
    wr(3'd7, 8'hF9);
    rchk("R9", 3'd7, 8'h09);

    // R8 every source code
    for (int c = 0; c < 8; c++) begin
      int dv;
      dv = (c == 0) ? D0 : (c == 1) ? D1 : (c == 2) ? D2 : (c == 3) ? D3 :
           (c == 4) ? D4 : (c == 5) ? D5 : 0;
      wr(3'd7, {4'h0, 3'(c), 1'b0});
      wr(3'd0, 8'h20);
      if (dv > 0) begin
        pulses(dv - 1);
        rchk("R8", 3'd0, 8'h20);
        pulses(1);
        rchk("R8", 3'd0, 8'h21);
      end else begin
        pulses(25);
        rchk("R8", 3'd0, 8'h20);
      end
    end

    // source: line 50 with divisor D4, 24-hour mode
    wr(3'd7, {4'h0, 3'd4, 1'b0});

    // R10 write in the same cycle as the due tick
    wr(3'd0, 8'h10);
    pulses(D4 - 1);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30; src_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; src_tick = 1'b0;
    rchk("R10", 3'd0, 8'h30);
    pulses(D4 - 1);
    rchk("R10", 3'd0, 8'h30);
    pulses(1);
    rchk("R10", 3'd0, 8'h31);
    // R10 a write mid-period restarts the count
    pulses(D4 - 1);
    wr(3'd1, 8'h05);
    pulses(D4 - 1);
    rchk("R10", 3'd0, 8'h31);
    pulses(1);
    rchk("R10", 3'd0, 8'h32);

    // R2 seconds sweep with minute carry
    wr(3'd1, 8'h07);
    for (int s = 0; s < 60; s++) begin
      wr(3'd0, bcd(s));
      wr(3'd1, 8'h07);
      pulses(D4);
      rchk("R2", 3'd0, bcd((s + 1) % 60));
      rchk("R2", 3'd1, (s == 59) ? 8'h08 : 8'h07);
    end

    // R3 / R4 / R5 hour sweeps in both modes
    for (int m = 0; m < 2; m++) begin
      wr(3'd7, {4'h0, 3'd4, 1'(m)});
      for (int h = 0; h < 24; h++) begin
        set_all(8'h59, 8'h59, m ? enc12(h) : bcd(h), 8'h07, 8'h15, 8'h06, 8'h24);
        pulses(D4);
        if (m == 1) rchk("R4", 3'd2, enc12((h + 1) % 24));
        else        rchk("R3", 3'd2, bcd((h + 1) % 24));
        rchk(m ? "R4" : "R3", 3'd4, (h == 23) ? 8'h16 : 8'h15);
        rchk("R5", 3'd3, (h == 23) ? 8'h01 : 8'h07);
        rchk("R2", 3'd1, 8'h00);
      end
    end
    wr(3'd7, {4'h0, 3'd4, 1'b0});

    // R6 month lengths in a non-leap year
    for (int mo = 1; mo <= 12; mo++) begin
      int ml;
      ml = mlen(mo, 23);
      set_all(8'h59, 8'h59, 8'h23, 8'h03, bcd(ml - 1), bcd(mo), 8'h23);
      pulses(D4);
      rchk("R6", 3'd4, bcd(ml));
      rchk("R5", 3'd3, 8'h04);
      wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h23);
      pulses(D4);
      rchk("R6", 3'd4, 8'h01);
      rchk("R6", 3'd5, bcd(mo % 12 + 1));
      rchk("R6", 3'd6, (mo == 12) ? 8'h24 : 8'h23);
    end

    // R7 February across every year
    for (int y = 0; y < 100; y++) begin
      logic lp;
      lp = (y % 4 == 0);
      set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, bcd(y));
      pulses(D4);
      rchk("R7", 3'd4, lp ? 8'h29 : 8'h01);
      rchk("R7", 3'd5, lp ? 8'h02 : 8'h03);
      if (lp) begin
        wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h23);
        pulses(D4);
        rchk("R7", 3'd4, 8'h01);
        rchk("R7", 3'd5, 8'h03);
      end
    end

    // R11 full rollover on one edge
    set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    pulses(D4 - 1);
    rchk("R11", 3'd6, 8'h99);
    pulses(1);
    rchk("R11", 3'd0, 8'h00); rchk("R11", 3'd1, 8'h00); rchk("R11", 3'd2, 8'h00);
    rchk("R11", 3'd3, 8'h01); rchk("R11", 3'd4, 8'h01); rchk("R11", 3'd5, 8'h01);
    rchk("R11", 3'd6, 8'h00);
    rd(3'd7, d);
    chk("R9", "ctrl kept", d, 8'h08);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule